// File: doc/BRIEF.md
# CAN Controller Interrupt Line Combiner

This block merges the interrupt sources of a CAN controller onto two output lines. Status events are qualified by a status enable: a receive completed, a transmit completed, or a new last-error code. Error events are qualified by an error enable: a protocol error flag, or a change in the bus-off or error-warning flags. A qualified event of either kind sets a sticky status-interrupt flag, which stays set until the CPU acknowledges it. The status line follows that flag, gated by a module line enable.

Message-object interrupts arrive as a count of pending objects. A routing enable selects where they appear. When it is set, a dedicated message-object line is high while the count is nonzero. When it is clear, that line stays low and the pending objects are folded into the status line instead. Both lines stay high until every source routed to them has been serviced.

All pins are plain control and status signals, so there is no valid/ready handshake. The event inputs are single-cycle pulses. The flag inputs and the pending count are levels.

Top module: `can_irq_combiner`

## Requirements
- R1: While `line_en` is 0, `irq_status` is 0 whatever the flag and the pending count are.
- R2: With `err_en` = 1, a cycle in which `prot_err` is 1 sets `stat_flag`, and the flag is seen 1 in the following cycle.
- R3: With `err_en` = 1, a cycle in which `bus_off` or `err_warn` differs from its value in the previous cycle sets `stat_flag` the next cycle. This holds for rising and falling changes alike. Both reference values reset to 0, and they follow the inputs every cycle whatever the enables are.
- R4: With `stat_en` = 1, a pulse on any of `ev_rx_ok`, `ev_tx_ok` or `ev_lec_upd` sets `stat_flag` the next cycle.
- R5: An error event while `err_en` = 0, or a status event while `stat_en` = 0, changes neither `stat_flag` nor `irq_status`.
- R6: `stat_flag` resets to 0 and holds its value until `stat_ack` is 1 in a cycle with no qualified event. The flag then reads 0 in the next cycle.
- R7: When a qualified event and `stat_ack` occur in the same cycle, the event wins and `stat_flag` is 1 in the next cycle.
- R8: With `mo_line_en` = 1, `irq_mo` is 1 exactly when `mo_pending` is nonzero, in the same cycle, and the pending count has no effect on `irq_status`.
- R9: With `mo_line_en` = 0, `irq_mo` is 0, and a nonzero `mo_pending` drives `irq_status` to 1 in the same cycle when `line_en` = 1.
- R10: `irq_status` equals `line_en` AND (`stat_flag` OR (NOT `mo_line_en` AND `mo_pending` nonzero)).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_en | input | 1 | Module status line enable |
| err_en | input | 1 | Error event enable |
| stat_en | input | 1 | Status event enable |
| mo_line_en | input | 1 | Route message-object interrupts to their own line |
| ev_rx_ok | input | 1 | Pulse: reception completed |
| ev_tx_ok | input | 1 | Pulse: transmission completed |
| ev_lec_upd | input | 1 | Pulse: last-error code updated |
| prot_err | input | 1 | Protocol error flag level |
| bus_off | input | 1 | Bus-off flag level |
| err_warn | input | 1 | Error-warning flag level |
| mo_pending | input | CNT_W | Number of pending message-object interrupts |
| stat_ack | input | 1 | CPU acknowledge clearing the status flag |
| irq_status | output | 1 | Status interrupt line |
| irq_mo | output | 1 | Message-object interrupt line |
| stat_flag | output | 1 | Sticky status-interrupt flag |

## Verification
The two functions that meet in one cycle are the setting of the sticky flag by a qualified event and its clearing by the CPU acknowledge. The sweep drives every event kind together with the acknowledge, and also alone, under every enable combination. A flag read of 1 in the following cycle shows that the event won. In the same cycles a nonzero pending count is applied, so the two sources of the status line meet as well. Their combination is judged against the OR expected for that routing choice.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  // indices into the watched error-flag vector
  localparam int unsigned FLAG_BUS_OFF  = 0;
  localparam int unsigned FLAG_ERR_WARN = 1;
  localparam int unsigned NUM_WATCHED   = 2;

  typedef struct packed {
    logic rx_ok;
    logic tx_ok;
    logic lec_upd;
  } stat_evt_t;

  typedef struct packed {
    logic                   prot_err;
    logic [NUM_WATCHED-1:0] changed;
  } err_evt_t;

endpackage

// File: rtl/can_irq_change_det.sv
module can_irq_change_det #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] chg
);

  logic [W-1:0] ref_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) ref_q[g] <= 1'b0;
      else        ref_q[g] <= lvl[g];
    end
    assign chg[g] = lvl[g] ^ ref_q[g];
  end

  // R3: the reference value tracks the input every cycle
  ref_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ref_q == $past(lvl)));

endmodule

// File: rtl/can_irq_flag.sv
module can_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic ack,
  output logic flag
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_req) flag_q <= 1'b1;
    else if (ack)     flag_q <= 1'b0;
  end

  assign flag = flag_q;

  // R7: a set request wins over a simultaneous acknowledge
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> flag);

  // R6: an acknowledge alone clears the flag
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set_req) |=> !flag);

  // R6: the flag holds when nothing acts on it
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !set_req) |=> $stable(flag));

endmodule

// File: rtl/can_irq_router.sv
module can_irq_router #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             line_en,
  input  logic             mo_line_en,
  input  logic             flag,
  input  logic [CNT_W-1:0] mo_pending,
  output logic             irq_status,
  output logic             irq_mo
);

  logic mo_any;

  always_comb begin
    mo_any     = (mo_pending != '0);
    irq_mo     = mo_line_en & mo_any;
    irq_status = line_en & (flag | (~mo_line_en & mo_any));
  end

endmodule

// File: rtl/can_irq_combiner.sv
module can_irq_combiner #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_en,
  input  logic             err_en,
  input  logic             stat_en,
  input  logic             mo_line_en,
  input  logic             ev_rx_ok,
  input  logic             ev_tx_ok,
  input  logic             ev_lec_upd,
  input  logic             prot_err,
  input  logic             bus_off,
  input  logic             err_warn,
  input  logic [CNT_W-1:0] mo_pending,
  input  logic             stat_ack,
  output logic             irq_status,
  output logic             irq_mo,
  output logic             stat_flag
);
  import can_irq_pkg::*;

  logic [NUM_WATCHED-1:0] watched;
  logic [NUM_WATCHED-1:0] watched_chg;
  stat_evt_t              sev;
  err_evt_t               eev;
  logic                   set_req;

  always_comb begin
    watched                = '0;
    watched[FLAG_BUS_OFF]  = bus_off;
    watched[FLAG_ERR_WARN] = err_warn;
  end

  can_irq_change_det #(.W(NUM_WATCHED)) i_chg (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (watched),
    .chg   (watched_chg)
  );

  always_comb begin
    sev.rx_ok    = ev_rx_ok;
    sev.tx_ok    = ev_tx_ok;
    sev.lec_upd  = ev_lec_upd;
    eev.prot_err = prot_err;
    eev.changed  = watched_chg;
    set_req      = (err_en & (|eev)) | (stat_en & (|sev));
  end

  can_irq_flag i_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (set_req),
    .ack     (stat_ack),
    .flag    (stat_flag)
  );

  can_irq_router #(.CNT_W(CNT_W)) i_route (
    .line_en    (line_en),
    .mo_line_en (mo_line_en),
    .flag       (stat_flag),
    .mo_pending (mo_pending),
    .irq_status (irq_status),
    .irq_mo     (irq_mo)
  );

  // R1
  line_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en |-> !irq_status);

  // R9
  mo_line_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mo_line_en |-> !irq_mo);

  // R2
  prot_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_en && prot_err) |=> stat_flag);

  // R4
  stat_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_en && (ev_rx_ok || ev_tx_ok || ev_lec_upd)) |=> stat_flag);

  // R5
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_en && !stat_en && !stat_ack) |=> $stable(stat_flag));

endmodule

// File: tb/test_can_irq_combiner.sv
module test_can_irq_combiner;
  localparam int PERIOD = 10;
  localparam int CNT_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_en = 0, err_en = 0, stat_en = 0, mo_line_en = 0;
  logic ev_rx_ok = 0, ev_tx_ok = 0, ev_lec_upd = 0;
  logic prot_err = 0, bus_off = 0, err_warn = 0, stat_ack = 0;
  logic [CNT_W-1:0] mo_pending = '0;
  logic irq_status, irq_mo, stat_flag;

  int total = 0;
  int bad   = 0;
  logic m_flag = 0, m_bo = 0, m_ew = 0;
  string last_tag = "R6";

  always #(PERIOD/2) clk = ~clk;

  can_irq_combiner #(.CNT_W(CNT_W)) i_can_irq_combiner (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .err_en(err_en),
    .stat_en(stat_en), .mo_line_en(mo_line_en), .ev_rx_ok(ev_rx_ok),
    .ev_tx_ok(ev_tx_ok), .ev_lec_upd(ev_lec_upd), .prot_err(prot_err),
    .bus_off(bus_off), .err_warn(err_warn), .mo_pending(mo_pending),
    .stat_ack(stat_ack), .irq_status(irq_status), .irq_mo(irq_mo),
    .stat_flag(stat_flag)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // inputs already driven; check outputs, then advance one clock
  task automatic step();
    logic mo_any, st_ev, er_ev, set;
    #1;
    mo_any = (mo_pending != 0);
    check(last_tag, stat_flag, m_flag);
    check(mo_line_en ? "R8" : "R9", irq_mo, mo_line_en & mo_any);
    check(!line_en ? "R1" : "R10", irq_status,
          line_en & (m_flag | (!mo_line_en & mo_any)));
    st_ev = ev_rx_ok | ev_tx_ok | ev_lec_upd;
    er_ev = prot_err | (bus_off != m_bo) | (err_warn != m_ew);
    set   = (stat_en & st_ev) | (err_en & er_ev);
    if (set && stat_ack)               last_tag = "R7";
    else if (err_en && prot_err)       last_tag = "R2";
    else if (err_en && er_ev)          last_tag = "R3";
    else if (stat_en && st_ev)         last_tag = "R4";
    else if (st_ev || er_ev)           last_tag = "R5";
    else                               last_tag = "R6";
    if (set)           m_flag = 1'b1;
    else if (stat_ack) m_flag = 1'b0;
    m_bo = bus_off;
    m_ew = err_warn;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R6", stat_flag, 1'b0);
    check("R1", irq_status, 1'b0);
    check("R9", irq_mo, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int en = 0; en < 16; en++) begin
      for (int ev = 0; ev < 8; ev++) begin
        for (int ak = 0; ak < 2; ak++) begin
          for (int c = 0; c < 3; c++) begin
            {line_en, err_en, stat_en, mo_line_en} = 4'(en);
            mo_pending = CNT_W'(c == 0 ? 0 : (c == 1 ? 1 : 15));
            ev_rx_ok   = (ev == 1) || (ev == 7);
            ev_tx_ok   = (ev == 2);
            ev_lec_upd = (ev == 3);
            prot_err   = (ev == 4) || (ev == 7);
            if (ev == 5) bus_off  = ~bus_off;
            if (ev == 6) err_warn = ~err_warn;
            stat_ack = ak[0];
            step();
            // quiet cycle to observe the flag with the count cleared
            {ev_rx_ok, ev_tx_ok, ev_lec_upd, prot_err, stat_ack} = '0;
            mo_pending = '0;
            step();
          end
        end
      end
    end
    // final acknowledge, then confirm the line has fallen
    {line_en, err_en, stat_en, mo_line_en} = 4'b1000;
    stat_ack = 1'b1;
    step();
    stat_ack = 1'b0;
    step();
    check("R6", stat_flag, 1'b0);
    check("R10", irq_status, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule